// File: doc/BRIEF.md
# Clock Prescaler Control Register

This block is one 8-bit control register on a simple register bus, together with the prescaler it drives. The prescaler works from the reference clock. Two fields pick independent divide ratios of 1, 2, 4 or 8: one field sets the system clock and the other sets a clock driven out on a port pin. A third field holds a 2-bit oscillator mode code. Software may change that code only while the high-speed oscillator is stopped. The block never produces a derived clock net. Each divided clock appears as a one-cycle enable pulse, timed by a free-running 3-bit phase counter.

Each divider lane is a four-state machine. Its states are `RATIO_1`, `RATIO_2`, `RATIO_4` and `RATIO_8`. The lane moves from its current state to the state that its code requests, and it does so only on the wrap transition, which is the cycle in which the phase counter goes from 7 to 0. It holds its state in every other cycle. In a state of ratio N, the lane pulses whenever the low log2(N) bits of the phase are zero. The output lane remaps one code: in PLL mode, code 00 requests `RATIO_2` instead of `RATIO_1`.

The register also keeps a sticky sequence-error flag. This flag catches a mode change made while the system is not running from the low-speed clock.

Top module: `pscl_ctrl`

## Requirements
- R1: After reset the register reads 0x0033, so both divide codes are 11 (divide by 8) and the mode is 00 (RC). The sequence-error flag reads 0.
- R2: Bits 1:0 set the `sys_ce` rate: code 00 gives an enable in every reference cycle, 01 in one cycle of every 2, 10 in one of every 4, and 11 in one of every 8.
- R3: Bits 5:4 set the `out_ce` rate with the same code-to-ratio mapping as bits 1:0.
- R4: When the mode field is 10 (built-in PLL), output code 00 gives one `out_ce` every 2 cycles. The other output codes and the system lane keep their normal ratios.
- R5: A write with `osc_en` = 1 leaves bits 3:2 unchanged, but the same write still updates bits 1:0 and 5:4.
- R6: A new ratio takes effect only at the wrap of the phase counter. Across a change, no gap between enable pulses is shorter than the smaller of the old and new ratios.
- R7: Bits 7:6 always read 0. A write whose byte enable selects only the high lane (`bus_be` = 10) changes nothing. A 16-bit write (`bus_be` = 11) updates the register from `bus_wdata[7:0]`.
- R8: Read bit 8 is a sticky sequence-error flag. It is set by an accepted write that changes bits 3:2 while `lowspd_sel` = 0. Later writes do not clear it; only reset does.
- R9: `osc_mode` always equals register bits 3:2 (00 RC, 01 crystal/ceramic, 10 PLL, 11 external clock).
- R10: When `bus_addr` differs from the register address, reads return 0 and writes have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that drives the prescaler |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register bus address (halfword aligned) |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte-lane enables: bit 0 is the low lane, bit 1 the high lane |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 16 | Read data: bits 5:0 are the fields, bit 8 is the error flag |
| osc_en | input | 1 | High-speed oscillator enabled; locks the mode field |
| lowspd_sel | input | 1 | The system currently runs from the low-speed clock |
| sys_ce | output | 1 | System clock enable pulse |
| out_ce | output | 1 | Port output clock enable pulse |
| osc_mode | output | 2 | Current oscillator mode code |

## Verification
A lane stuck in the wrong ratio state shows up as the wrong enable count within one 8-cycle phase period after the next wrap. Counting pulses over 32 cycles therefore exposes it for every code, in both PLL and non-PLL mode. A lane that switches before the wrap produces a short gap between pulses right after the write, so the gap trace around a ratio change catches it. A mode field that accepts a locked write appears at once, in the read data and on `osc_mode`, in the cycle after the write.

// File: rtl/pscl_pkg.sv
package pscl_pkg;

    localparam int PHASE_W = 3;

    typedef enum logic [1:0] {
        OSC_RC   = 2'b00,
        OSC_XTAL = 2'b01,
        OSC_PLL  = 2'b10,
        OSC_EXT  = 2'b11
    } osc_mode_e;

    typedef enum logic [1:0] {
        RATIO_1 = 2'b00,
        RATIO_2 = 2'b01,
        RATIO_4 = 2'b10,
        RATIO_8 = 2'b11
    } ratio_e;

    typedef struct packed {
        logic [1:0] out_code;
        osc_mode_e  mode;
        logic [1:0] sys_code;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{out_code: 2'b11, mode: OSC_RC, sys_code: 2'b11};

endpackage

// File: rtl/pscl_phase.sv
module pscl_phase
    import pscl_pkg::*;
#(
    parameter int W = PHASE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] phase_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] LAST = {W{1'b1}};

    logic [W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
    end

    assign phase_o = phase_q;
    assign wrap_o  = (phase_q == LAST);

    a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (phase_o == '0));

endmodule

// File: rtl/pscl_regbank.sv
module pscl_regbank
    import pscl_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = 12'h002
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [15:0]       wdata_i,
    input  logic [1:0]        be_i,
    input  logic              wr_i,
    output logic [15:0]       rdata_o,
    input  logic              osc_en_i,
    input  logic              lowspd_i,
    output ctl_t              ctl_o
);
    ctl_t      ctl_q;
    logic      err_q;
    logic      hit;
    logic      wr_lo;
    logic      mode_open;
    osc_mode_e mode_req;
    osc_mode_e mode_q;

    assign hit       = (addr_i == REG_ADDR);
    assign wr_lo     = wr_i && hit && be_i[0];
    assign mode_open = !osc_en_i;
    assign mode_req  = osc_mode_e'(wdata_i[3:2]);
    assign mode_q    = ctl_q.mode;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
            err_q <= 1'b0;
        end else if (wr_lo) begin
            ctl_q.sys_code <= wdata_i[1:0];
            ctl_q.out_code <= wdata_i[5:4];
            if (mode_open) ctl_q.mode <= mode_req;
            if (mode_open && !lowspd_i && (mode_req != ctl_q.mode)) err_q <= 1'b1;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (hit) rdata_o = {7'b0, err_q, 2'b00, ctl_q};
    end

    assign ctl_o = ctl_q;

    a_r5_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en_i && wr_i) |=> $stable(mode_q));

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[8] && hit |=> (!hit || rdata_o[8]));

    a_r10_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !hit) |=> $stable(ctl_q));

    a_r7_high_lane_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !be_i[0]) |=> $stable(ctl_q));

endmodule

// File: rtl/pscl_lane.sv
module pscl_lane
    import pscl_pkg::*;
#(
    parameter bit REMAP_PLL = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         code_i,
    input  logic               pll_i,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               wrap_i,
    output logic               ce_o,
    output ratio_e             ratio_o
);
    ratio_e state_q;
    ratio_e req;

    generate
        if (REMAP_PLL) begin : g_remap
            always_comb begin
                req = ratio_e'(code_i);
                if (pll_i && (code_i == 2'b00)) req = RATIO_2;
            end
        end else begin : g_plain
            assign req = ratio_e'(code_i);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)      state_q <= RATIO_8;
        else if (wrap_i) state_q <= req;
    end

    always_comb begin
        unique case (state_q)
            RATIO_1: ce_o = 1'b1;
            RATIO_2: ce_o = !phase_i[0];
            RATIO_4: ce_o = (phase_i[1:0] == 2'b00);
            RATIO_8: ce_o = (phase_i == '0);
            default: ce_o = 1'b0;
        endcase
    end

    assign ratio_o = state_q;

    a_r6_hold_between_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable(state_q));

    a_r2_pulse_at_phase_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> ce_o);

endmodule

// File: rtl/pscl_ctrl.sv
module pscl_ctrl
    import pscl_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = 12'h002
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic [1:0]        bus_be,
    input  logic              bus_wr,
    output logic [15:0]       bus_rdata,
    input  logic              osc_en,
    input  logic              lowspd_sel,
    output logic              sys_ce,
    output logic              out_ce,
    output logic [1:0]        osc_mode
);
    localparam int LANES = 2;

    ctl_t               ctl;
    logic [PHASE_W-1:0] phase;
    logic               wrap;
    logic               pll_on;
    logic [1:0]         lane_code [LANES];
    logic [LANES-1:0]   lane_ce;
    ratio_e             lane_ratio [LANES];

    pscl_regbank #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .be_i     (bus_be),
        .wr_i     (bus_wr),
        .rdata_o  (bus_rdata),
        .osc_en_i (osc_en),
        .lowspd_i (lowspd_sel),
        .ctl_o    (ctl)
    );

    pscl_phase #(.W(PHASE_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase),
        .wrap_o  (wrap)
    );

    assign pll_on       = (ctl.mode == OSC_PLL);
    assign lane_code[0] = ctl.sys_code;
    assign lane_code[1] = ctl.out_code;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            pscl_lane #(.REMAP_PLL(g == 1)) u_lane (
                .clk     (clk),
                .rst_n   (rst_n),
                .code_i  (lane_code[g]),
                .pll_i   (pll_on),
                .phase_i (phase),
                .wrap_i  (wrap),
                .ce_o    (lane_ce[g]),
                .ratio_o (lane_ratio[g])
            );
        end
    endgenerate

    assign sys_ce   = lane_ce[0];
    assign out_ce   = lane_ce[1];
    assign osc_mode = ctl.mode;

    a_r4_pll_no_div1: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && pll_on) |=> (lane_ratio[1] != RATIO_1));

    a_r9_mode_pin_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_ADDR) |-> (osc_mode == bus_rdata[3:2]));

endmodule

// File: tb/pscl_ctrl_test.sv
module pscl_ctrl_test;

    localparam logic [11:0] RA = 12'h002;
    localparam int NV = 10;
    // {register byte, expected system ratio, expected output ratio}
    localparam logic [23:0] VECS [NV] = '{
        24'h30_01_08, 24'h21_02_04, 24'h12_04_02, 24'h03_08_01,
        24'h38_01_08, 24'h29_02_04, 24'h1A_04_02, 24'h0B_08_02,
        24'h0C_01_01, 24'h05_02_01
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = RA;
    logic [15:0] bus_wdata = '0;
    logic [1:0]  bus_be = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_rdata;
    logic        osc_en = 1'b0;
    logic        lowspd_sel = 1'b1;
    logic        sys_ce, out_ce;
    logic [1:0]  osc_mode;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pscl_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
        .osc_en(osc_en), .lowspd_sel(lowspd_sel),
        .sys_ce(sys_ce), .out_ce(out_ce), .osc_mode(osc_mode)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_at(input logic [11:0] a, input logic [15:0] d, input logic [1:0] b);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = b; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = RA;
    endtask

    task automatic rd(output logic [15:0] v);
        bus_addr = RA;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic count32(output int ns, output int no);
        ns = 0; no = 0;
        repeat (10) @(negedge clk);
        repeat (32) begin
            @(negedge clk);
            ns += int'(sys_ce);
            no += int'(out_ce);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [15:0] v;
        int ns, no;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(v);
        chk("R1 reset value", v, 16'h0033);
        chk("R9 reset mode pin", osc_mode, 0);
        count32(ns, no);
        chk("R1 reset sys ratio 8", ns, 4);
        chk("R1 reset out ratio 8", no, 4);

        // R2 R3 R4 R9 vector table
        for (int i = 0; i < NV; i++) begin
            wr_at(RA, {8'h00, VECS[i][23:16]}, 2'b01);
            rd(v);
            chk("R2 readback", v, {8'h00, VECS[i][23:16]});
            chk("R9 mode pin", osc_mode, VECS[i][19:18]);
            count32(ns, no);
            chk("R2 sys rate", ns, 32 / VECS[i][15:8]);
            if (VECS[i][19:18] == 2'b10) chk("R4 out rate in PLL", no, 32 / VECS[i][7:0]);
            else                         chk("R3 out rate", no, 32 / VECS[i][7:0]);
        end

        // R10 other address: no write, reads 0
        wr_at(12'h004, 16'h0000, 2'b11);
        rd(v);
        chk("R10 miss write ignored", v, 16'h0005);
        bus_addr = 12'h004; #0.5;
        chk("R10 miss read zero", bus_rdata, 0);
        bus_addr = RA;

        // R5 locked mode field
        osc_en = 1'b1;
        wr_at(RA, 16'h002A, 2'b01);
        rd(v);
        chk("R5 locked write keeps mode", v, 16'h0026);
        chk("R5 mode pin held", osc_mode, 1);
        osc_en = 1'b0;

        // R7 reserved bits and byte lanes
        wr_at(RA, 16'h00F3, 2'b01);
        rd(v);
        chk("R7 bits 7:6 read zero", v, 16'h0033);
        wr_at(RA, 16'h0000, 2'b10);
        rd(v);
        chk("R7 high lane only ignored", v, 16'h0033);
        wr_at(RA, 16'hFF21, 2'b11);
        rd(v);
        chk("R7 halfword low lane", v, 16'h0021);

        // R6 ratio change from 2 to 8, mid-period
        begin
            int last, mingap, lastgap;
            last = -1; mingap = 99; lastgap = 0;
            repeat (3) @(negedge clk);
            for (int k = 0; k < 48; k++) begin
                if (k == 5) begin bus_wdata = 16'h0023; bus_be = 2'b01; bus_wr = 1'b1; end
                else bus_wr = 1'b0;
                if (sys_ce) begin
                    if (last >= 0) begin
                        lastgap = k - last;
                        if (lastgap < mingap) mingap = lastgap;
                    end
                    last = k;
                end
                @(negedge clk);
            end
            bus_wr = 1'b0;
            chk("R6 no short interval", (mingap >= 2) ? 1 : 0, 1);
            chk("R6 new ratio in force", lastgap, 8);
        end

        // R8 sticky sequence error
        lowspd_sel = 1'b0;
        wr_at(RA, 16'h0023, 2'b01);
        rd(v);
        chk("R8 same mode no error", v, 16'h0023);
        wr_at(RA, 16'h0027, 2'b01);
        rd(v);
        chk("R8 error set", v, 16'h0127);
        lowspd_sel = 1'b1;
        wr_at(RA, 16'h0023, 2'b01);
        rd(v);
        chk("R8 error sticky", v, 16'h0123);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd(v);
        chk("R8 R1 reset clears", v, 16'h0033);

        summary();
    end

endmodule